// File: doc/BRIEF.md
# SONET Framing Defect Monitor

This block sits behind a SONET framer and turns a per-frame framing verdict into defect states. Each frame boundary shows up as a one-cycle strobe. With that strobe comes a flag that tells whether the frame's A1/A2 alignment bytes were corrupted. From this stream the block keeps a Severely Erred Frame (SEF) state and a Loss of Frame (LOF) state, both with hysteresis. It also mirrors a loss-of-signal level that arrives on a separate pin. Every change of any of the three conditions is latched into an interrupt status register, and that register clears when it is read. An active-low interrupt pin asserts while any latched event whose enable bit is set is still pending.

The frame input is a strobe with no back-pressure. The block accepts a verdict on every cycle in which `frame_tick` is high, and it has no ready signal because it can never stall. Software uses a plain register port with no handshake. Read data is combinational from the address. A read of the interrupt status address clears that register at the next clock edge. A write takes effect at the clock edge. Reset leaves the block in the out-of-frame state, with both SEF and LOF declared and no events pending.

Top module: `frm_defect_mon`

## Requirements
- R1: After reset the status register reads 0x06 (SEF=1, LOF=1, LOS=0). The interrupt status register and the interrupt enable register both read 0x00, and `irq_n` is high.
- R2: While SEF is clear, SEF is declared on the fourth consecutive frame strobe that carries `frame_err`=1. A clean frame before the fourth one restarts the count.
- R3: While SEF is declared, SEF is cleared on the second consecutive frame strobe that carries `frame_err`=0. An errored frame between them restarts the count.
- R4: LOF is declared on the 24th consecutive frame strobe that arrives while SEF was already declared before that strobe.
- R5: LOF is cleared on the 24th consecutive frame strobe that arrives while SEF was already clear before that strobe. A strobe that sees SEF declared restarts this count.
- R6: Address 0 is the read-only status register. Bit 0 is LOS, bit 1 is SEF, bit 2 is LOF, and bits 7:3 read zero.
- R7: Address 1 is the interrupt status register, with the same bit positions as the status register. A bit is set on every change of its condition, in both directions. All bits clear at the clock edge on which address 1 is read.
- R8: An event that arrives on the same edge as a read of address 1 stays latched after the read. The read itself returns the value from before that edge.
- R9: Address 2 is the interrupt enable register, writable in bits 2:0. `irq_n` is low exactly when some interrupt status bit and its enable bit are both set.
- R10: The status LOS bit follows `los_in` one edge later. Every rising or falling edge of `los_in` sets interrupt status bit 0.
- R11: `frame_err` is ignored in cycles where `frame_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle frame boundary strobe |
| frame_err | input | 1 | Framing bytes of this frame were errored, qualified by frame_tick |
| los_in | input | 1 | Loss-of-signal level |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check several rules on every cycle:
- SEF and LOF change only on a frame strobe.
- SEF can rise only on an errored frame and fall only on a clean one.
- LOF moves only in the direction that the previous SEF state permits.
- Every change of SEF sets its pending event.
- A pending event stays set until a read of the interrupt status register.
- LOS tracks its pin.

The exact counts of 4, 2 and 24 frames depend on frame history, so only the bench's scenarios can show them. The bench applies every 8-frame error pattern and sweeps run lengths across the LOF threshold, comparing each frame against an arithmetic model. It also covers the read that coincides with a new event and the masking of events by the enable register.

// File: rtl/frm_defect_pkg.sv
package frm_defect_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_ISR  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_IEN  = 2'd2;
  localparam int unsigned NUM_COND = 3;

  // bit order is shared by status, event and enable registers
  typedef struct packed {
    logic lof;
    logic sef;
    logic los;
  } cond_t;
endpackage

// File: rtl/frm_sef_ctl.sv
module frm_sef_ctl #(
  parameter int unsigned SET_FRAMES = 4,
  parameter int unsigned CLR_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic err,
  output logic sef,
  output logic sef_chg
);
  localparam int unsigned EW = $clog2(SET_FRAMES + 1);
  localparam int unsigned CW = $clog2(CLR_FRAMES + 1);

  logic [EW-1:0] bad_q, bad_d;
  logic [CW-1:0] good_q, good_d;
  logic          sef_q, sef_d;

  always_comb begin
    bad_d  = bad_q;
    good_d = good_q;
    sef_d  = sef_q;
    if (tick) begin
      if (err) begin
        good_d = '0;
        if (!sef_q) begin
          if (bad_q == EW'(SET_FRAMES - 1)) begin
            sef_d = 1'b1;
            bad_d = '0;
          end else begin
            bad_d = bad_q + 1'b1;
          end
        end
      end else begin
        bad_d = '0;
        if (sef_q) begin
          if (good_q == CW'(CLR_FRAMES - 1)) begin
            sef_d  = 1'b0;
            good_d = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q  <= '0;
      good_q <= '0;
      sef_q  <= 1'b1;
    end else begin
      bad_q  <= bad_d;
      good_q <= good_d;
      sef_q  <= sef_d;
    end
  end

  assign sef     = sef_q;
  assign sef_chg = sef_d ^ sef_q;
endmodule

// File: rtl/frm_lof_timer.sv
module frm_lof_timer #(
  parameter int unsigned SET_FRAMES = 24,
  parameter int unsigned CLR_FRAMES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sef,
  output logic lof,
  output logic lof_chg
);
  localparam int unsigned SW = $clog2(SET_FRAMES + 1);
  localparam int unsigned CW = $clog2(CLR_FRAMES + 1);

  logic [SW-1:0] up_q, up_d;
  logic [CW-1:0] dn_q, dn_d;
  logic          lof_q, lof_d;

  always_comb begin
    up_d  = up_q;
    dn_d  = dn_q;
    lof_d = lof_q;
    if (tick) begin
      if (sef) begin
        dn_d = '0;
        if (!lof_q) begin
          if (up_q == SW'(SET_FRAMES - 1)) begin
            lof_d = 1'b1;
            up_d  = '0;
          end else begin
            up_d = up_q + 1'b1;
          end
        end
      end else begin
        up_d = '0;
        if (lof_q) begin
          if (dn_q == CW'(CLR_FRAMES - 1)) begin
            lof_d = 1'b0;
            dn_d  = '0;
          end else begin
            dn_d = dn_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= '0;
      dn_q  <= '0;
      lof_q <= 1'b1;
    end else begin
      up_q  <= up_d;
      dn_q  <= dn_d;
      lof_q <= lof_d;
    end
  end

  assign lof     = lof_q;
  assign lof_chg = lof_d ^ lof_q;
endmodule

// File: rtl/frm_irq_bank.sv
module frm_irq_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] pend,
  output logic [N-1:0] en,
  output logic         irq_n
);
  logic [N-1:0] pend_q;
  logic [N-1:0] en_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        // a new event wins over the read clear
        pend_q[i] <= evt[i] | (pend_q[i] & ~clr);
        if (en_we) en_q[i] <= en_wdata[i];
      end
    end
  end

  assign pend  = pend_q;
  assign en    = en_q;
  assign irq_n = ~|(pend_q & en_q);
endmodule

// File: rtl/frm_defect_mon.sv
module frm_defect_mon
  import frm_defect_pkg::*;
#(
  parameter int unsigned SEF_SET_FRAMES = 4,
  parameter int unsigned SEF_CLR_FRAMES = 2,
  parameter int unsigned LOF_SET_FRAMES = 24,
  parameter int unsigned LOF_CLR_FRAMES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              frame_err,
  input  logic              los_in,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic              irq_n
);
  localparam int unsigned PAD = REG_DW - NUM_COND;

  logic  sef_st, sef_chg;
  logic  lof_st, lof_chg;
  logic  los_st;
  cond_t evt, stat;
  logic [NUM_COND-1:0] int_st, int_en;
  logic  isr_clr, ien_we;

  frm_sef_ctl #(
    .SET_FRAMES(SEF_SET_FRAMES),
    .CLR_FRAMES(SEF_CLR_FRAMES)
  ) u_sef (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (frame_tick),
    .err    (frame_err),
    .sef    (sef_st),
    .sef_chg(sef_chg)
  );

  frm_lof_timer #(
    .SET_FRAMES(LOF_SET_FRAMES),
    .CLR_FRAMES(LOF_CLR_FRAMES)
  ) u_lof (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (frame_tick),
    .sef    (sef_st),
    .lof    (lof_st),
    .lof_chg(lof_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) los_st <= 1'b0;
    else        los_st <= los_in;
  end

  always_comb begin
    evt.los  = los_in ^ los_st;
    evt.sef  = sef_chg;
    evt.lof  = lof_chg;
    stat.los = los_st;
    stat.sef = sef_st;
    stat.lof = lof_st;
  end

  assign isr_clr = rd_en && (rd_addr == ADDR_ISR);
  assign ien_we  = wr_en && (wr_addr == ADDR_IEN);

  frm_irq_bank #(.N(NUM_COND)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .clr     (isr_clr),
    .en_we   (ien_we),
    .en_wdata(wr_data[NUM_COND-1:0]),
    .pend    (int_st),
    .en      (int_en),
    .irq_n   (irq_n)
  );

  always_comb begin
    case (rd_addr)
      ADDR_STAT: rd_data = {{PAD{1'b0}}, stat};
      ADDR_ISR:  rd_data = {{PAD{1'b0}}, int_st};
      ADDR_IEN:  rd_data = {{PAD{1'b0}}, int_en};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/frm_defect_mon_chk.sv
module frm_defect_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick,
  input logic       frame_err,
  input logic       los_in,
  input logic       rd_en,
  input logic [1:0] rd_addr,
  input logic       irq_n,
  input logic       sef_st,
  input logic       lof_st,
  input logic       los_st,
  input logic [2:0] int_st
);
  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(sef_st) && $stable(lof_st)));

  assert_sef_rise_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sef_st) |-> $past(frame_tick && frame_err));

  assert_sef_fall_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sef_st) |-> $past(frame_tick && !frame_err));

  assert_lof_rise_sef_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof_st) |-> $past(sef_st));

  assert_lof_fall_nosef_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof_st) |-> !$past(sef_st));

  assert_sef_evt_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sef_st) |-> int_st[1]);

  assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_st[1]) && !$past(rd_en && rd_addr == 2'd1)) |-> int_st[1]);

  assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (int_st != 3'b000));

  assert_los_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (los_st == $past(los_in)));
endmodule

bind frm_defect_mon frm_defect_mon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_tick(frame_tick),
  .frame_err (frame_err),
  .los_in    (los_in),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .irq_n     (irq_n),
  .sef_st    (sef_st),
  .lof_st    (lof_st),
  .los_st    (los_st),
  .int_st    (int_st)
);

// File: tb/sim_frm_defect_mon.sv
module sim_frm_defect_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0, frame_err = 1'b0, los_in = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] rd_addr = 2'd0, wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq_n;

  always #5 clk = ~clk;

  frm_defect_mon u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .frame_err(frame_err),
    .los_in(los_in), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_n(irq_n)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // arithmetic reference state
  bit m_sef = 1, m_lof = 1, m_los = 0;
  int m_ec = 0, m_cc = 0, m_ls = 0, m_lc = 0;
  logic [2:0] m_ist = 3'b000, m_ien = 3'b000;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(posedge clk);
    #1 rd_en = 1'b0;
    if (a == 2'd1) m_ist = 3'b000;
  endtask

  task automatic wr_ien(input logic [2:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = {5'd0, v};
    @(posedge clk);
    #1 wr_en = 1'b0;
    m_ien = v;
  endtask

  function automatic void model_frame(input bit e);
    bit pre_sef = m_sef;
    bit pre_lof = m_lof;
    if (e) begin
      m_cc = 0;
      if (!m_sef) begin m_ec++; if (m_ec >= 4) begin m_sef = 1; m_ec = 0; end end
    end else begin
      m_ec = 0;
      if (m_sef) begin m_cc++; if (m_cc >= 2) begin m_sef = 0; m_cc = 0; end end
    end
    if (pre_sef) begin
      m_lc = 0;
      if (!m_lof) begin m_ls++; if (m_ls >= 24) begin m_lof = 1; m_ls = 0; end end
    end else begin
      m_ls = 0;
      if (m_lof) begin m_lc++; if (m_lc >= 24) begin m_lof = 0; m_lc = 0; end end
    end
    if (m_sef != pre_sef) m_ist[1] = 1'b1;
    if (m_lof != pre_lof) m_ist[2] = 1'b1;
  endfunction

  task automatic frame(input bit e);
    @(negedge clk);
    frame_tick = 1'b1; frame_err = e;
    @(posedge clk);
    #1 frame_tick = 1'b0; frame_err = 1'b0;
    model_frame(e);
  endtask

  task automatic verify();
    logic [7:0] d;
    #1 chk("R9 irq_n", int'(irq_n), int'(!(|(m_ist & m_ien))));
    rd(2'd0, d);
    chk("R2 R3 R4 R5 R6 status", int'(d), int'({5'd0, m_lof, m_sef, m_los}));
  endtask

  task automatic check_isr(input string tag);
    logic [7:0] d;
    logic [2:0] e = m_ist;
    rd(2'd1, d);
    chk(tag, int'(d), int'({5'd0, e}));
  endtask

  task automatic frames(input int n, input bit e);
    for (int i = 0; i < n; i++) begin frame(e); verify(); end
  endtask

  task automatic set_los(input bit v);
    @(negedge clk);
    los_in = v;
    @(posedge clk);
    #1;
    if (v != m_los) m_ist[0] = 1'b1;
    m_los = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_n", int'(irq_n), 1);
    rd(2'd0, d); chk("R1 status", int'(d), 8'h06);
    rd(2'd2, d); chk("R1 enable", int'(d), 0);
    rd(2'd1, d); chk("R1 isr", int'(d), 0);

    // R9 enable register write/readback
    wr_ien(3'b111);
    rd(2'd2, d); chk("R9 enable readback", int'(d), 8'h07);

    // R3 then R5: recover frame, then LOF clears after 24 clean frames
    frames(1, 1'b0);
    check_isr("R3 isr no change after one clean");
    frames(1, 1'b0);
    frames(30, 1'b0);
    check_isr("R7 isr after SEF and LOF clear");

    // R2 run-length sweep of errored frames
    for (int n = 1; n <= 6; n++) begin
      frames(n, 1'b1);
      frames(30, 1'b0);
      check_isr("R2 R7 isr after errored run");
    end

    // R4 R5 persistence sweep around the LOF threshold
    for (int k = 22; k <= 30; k++) begin
      frames(k, 1'b1);
      frames(2, 1'b0);
      frames(1, 1'b1);
      frames(1, 1'b0);
      frames(40, 1'b0);
      check_isr("R4 R5 isr after long run");
    end

    // exhaustive 8-frame error patterns
    for (int p = 0; p < 256; p++) begin
      for (int b = 0; b < 8; b++) frames(1, p[b]);
      check_isr("R2 R3 R7 isr pattern");
    end

    // R11 frame_err without strobe has no effect
    frames(30, 1'b0);
    check_isr("R11 prep");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); frame_err = 1'b1;
    end
    @(negedge clk); frame_err = 1'b0;
    rd(2'd0, d); chk("R11 status unchanged", int'(d), int'({5'd0, m_lof, m_sef, m_los}));
    rd(2'd1, d); chk("R11 no event", int'(d), 0);

    // R8 event coinciding with a read of the event register
    frames(3, 1'b1);
    check_isr("R8 prep");
    @(negedge clk);
    frame_tick = 1'b1; frame_err = 1'b1; rd_en = 1'b1; rd_addr = 2'd1;
    #1 d = rd_data;
    @(posedge clk);
    #1 frame_tick = 1'b0; frame_err = 1'b0; rd_en = 1'b0;
    m_ist = 3'b000;
    model_frame(1'b1);
    chk("R8 read returns old value", int'(d), 0);
    chk("R8 sef declared", int'(m_sef), 1);
    rd(2'd1, d); chk("R8 event kept", int'(d), 8'h02);
    m_ist = 3'b000;

    // R10 LOS mirror and events on both edges
    set_los(1'b1);
    rd(2'd0, d); chk("R10 los high", int'(d[0]), 1);
    check_isr("R10 rise event");
    set_los(1'b0);
    rd(2'd0, d); chk("R10 los low", int'(d[0]), 0);
    check_isr("R10 fall event");

    // R9 masking: event pending but not enabled
    wr_ien(3'b001);
    frames(2, 1'b0);
    chk("R9 masked irq high", int'(irq_n), 1);
    wr_ien(3'b010);
    #1 chk("R9 enabled irq low", int'(irq_n), 0);
    check_isr("R9 isr");
    #1 chk("R9 irq released", int'(irq_n), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule